// File: doc/BRIEF.md
# Toggle-Rate Threshold Voltage Scaler

This block closes a fast power-management loop on one number: how many times the core's switched-capacitor regulator toggled during the last measurement window. Each toggle delivers a roughly fixed amount of energy, so the count works as a direct power proxy. In voltage mode the block picks one of two supply modes for the core. It drops to the low mode when the count shows the core is idle, and returns to the high mode when the count shows load. Two separate thresholds give the loop hysteresis. After each mode switch, a programmable number of windows is ignored so that the transient of the switch cannot cause chatter.

In power-cap mode the voltage mode is frozen. The block computes a quadratic power estimate from the count using three preloaded coefficients, then compares it with a budget that can be rewritten at any time. It moves a frequency setting one code down when the estimate exceeds the budget, and one code up otherwise. Every decision is taken on the same clock edge that delivers the window count, so the loop reacts within one cycle of a new measurement.

Top module: `trs_top`

## Requirements
- R1: After reset `modeHigh` is 1 (high mode, the 1.8 V supply halved), `freqCode` is its maximum code (all ones), and no blanking is pending.
- R2: In voltage operation (`capEn`=0), with no blanking pending and `thrLow` <= `thrHigh`, a window whose count is strictly below `thrLow` while `modeHigh`=1 clears `modeHigh` (low mode, the 1 V supply at two-thirds) at the edge that takes the window.
- R3: Under the same conditions, a window whose count is strictly above `thrHigh` while `modeHigh`=0 sets `modeHigh` at the edge that takes the window.
- R4: A count from `thrLow` to `thrHigh` inclusive never changes the mode, and neither does a count below `thrLow` in low mode or a count above `thrHigh` in high mode.
- R5: While `thrLow` > `thrHigh` the mode holds, whatever the counts.
- R6: After a mode change the next `blankWin` windows take no mode decision. The window after them decides normally. A `blankWin` of 0 means no blanking.
- R7: Outputs change only on an edge where `winValid` is 1. Counts presented with `winValid`=0 have no effect.
- R8: In power-cap operation (`capEn`=1), each window computes est = coefQuad*n*n + coefLin*n + coefConst, where n is the count. If est > `budget`, `freqCode` falls by one. Otherwise it rises by one.
- R9: `freqCode` saturates: a down step at code 0 leaves 0, and an up step at the maximum code leaves the maximum.
- R10: While `capEn`=1 the voltage mode holds. While `capEn`=0 `freqCode` holds. Blanking windows still count down in either operation.
- R11: `budget` is sampled on the deciding edge, so a rewrite applies to the very next window. An estimate exactly equal to the budget steps up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| winValid | input | 1 | A new window count is presented this cycle |
| winCount | input | CNT_W | Regulator toggle count of the finished window |
| capEn | input | 1 | 1 = power-cap operation, 0 = voltage operation |
| thrLow | input | CNT_W | Idle threshold used in high mode |
| thrHigh | input | CNT_W | Load threshold used in low mode |
| blankWin | input | BLANK_W | Windows ignored after a mode change |
| coefQuad | input | COEF_W | Quadratic coefficient of the estimate |
| coefLin | input | COEF_W | Linear coefficient of the estimate |
| coefConst | input | COEF_W | Constant term of the estimate |
| budget | input | EST_W | Power budget, in estimate units |
| modeHigh | output | 1 | 1 = high supply mode, 0 = low supply mode |
| freqCode | output | FREQ_W | Frequency setting |

## Verification
On every cycle, the assertions check the following:
- Mode and frequency move only on window edges.
- A blanking window never switches the mode.
- Inverted thresholds freeze the mode.
- Each operation leaves the other output untouched.
- The frequency moves by at most one code and saturates at both ends.

The bench's scenarios cover what the assertions cannot. They sweep the count through full ramps up and down against a reference model. This shows that the hysteresis direction and the strict-inequality boundaries are correct. The scenarios also show that the quadratic estimate matches the arithmetic, that an estimate equal to the budget steps up, and that exactly `blankWin` windows are skipped before the next decision.

// File: rtl/trs_pkg.sv
package trs_pkg;
  // Conditions the datapath reports to the control.
  typedef struct packed {
    logic isHigh;      // current supply mode
    logic belowLow;    // count < thrLow
    logic aboveHigh;   // count > thrHigh
    logic thrOk;       // thrLow <= thrHigh
    logic overBudget;  // estimate > budget
  } trs_flags_t;

  // Strobes the control issues to the datapath.
  typedef struct packed {
    logic toLow;
    logic toHigh;
    logic freqDn;
    logic freqUp;
  } trs_strobe_t;
endpackage

// File: rtl/trs_datapath.sv
module trs_datapath
  import trs_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int COEF_W = 8,
  parameter int FREQ_W = 3,
  parameter int EST_W  = COEF_W + 2*CNT_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  winCount,
  input  logic [CNT_W-1:0]  thrLow,
  input  logic [CNT_W-1:0]  thrHigh,
  input  logic [COEF_W-1:0] coefQuad,
  input  logic [COEF_W-1:0] coefLin,
  input  logic [COEF_W-1:0] coefConst,
  input  logic [EST_W-1:0]  budget,
  input  trs_strobe_t       strobe,
  output trs_flags_t        flags,
  output logic              modeHigh,
  output logic [FREQ_W-1:0] freqCode
);
  localparam logic [FREQ_W-1:0] FREQ_MAX = {FREQ_W{1'b1}};

  logic [EST_W-1:0] cntWide;
  logic [EST_W-1:0] cntSq;
  logic [EST_W-1:0] estimate;

  // Quadratic power estimate, widened so no term overflows.
  always_comb begin
    cntWide  = EST_W'(winCount);
    cntSq    = cntWide * cntWide;
    estimate = EST_W'(coefQuad) * cntSq
             + EST_W'(coefLin) * cntWide
             + EST_W'(coefConst);
  end

  always_comb begin
    flags.isHigh     = modeHigh;
    flags.belowLow   = winCount < thrLow;
    flags.aboveHigh  = winCount > thrHigh;
    flags.thrOk      = thrLow <= thrHigh;
    flags.overBudget = estimate > budget;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeHigh <= 1'b1;
    end else if (strobe.toLow) begin
      modeHigh <= 1'b0;
    end else if (strobe.toHigh) begin
      modeHigh <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      freqCode <= FREQ_MAX;
    end else if (strobe.freqDn && freqCode != '0) begin
      freqCode <= freqCode - 1'b1;
    end else if (strobe.freqUp && freqCode != FREQ_MAX) begin
      freqCode <= freqCode + 1'b1;
    end
  end

  // R5: inverted thresholds freeze the mode
  a_r5_bad_thr_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(thrLow <= thrHigh) |=> $stable(modeHigh));
  // R9: saturation at both ends
  a_r9_sat_top: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.freqUp && freqCode == FREQ_MAX) |=> freqCode == FREQ_MAX);
  a_r9_sat_bottom: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.freqDn && freqCode == '0) |=> freqCode == '0);
  // R8: one code per decision
  a_r8_single_step: assert property (@(posedge clk) disable iff (!rstN)
    freqCode != $past(freqCode) |->
      (freqCode == $past(freqCode) + 1'b1 || freqCode == $past(freqCode) - 1'b1));
endmodule

// File: rtl/trs_control.sv
module trs_control
  import trs_pkg::*;
#(
  parameter int BLANK_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               winValid,
  input  logic               capEn,
  input  logic [BLANK_W-1:0] blankWin,
  input  trs_flags_t         flags,
  output trs_strobe_t        strobe
);
  logic [BLANK_W-1:0] blankCnt;
  logic               decideOk;
  logic               voltTurn;

  always_comb begin
    decideOk      = winValid && (blankCnt == '0);
    voltTurn      = decideOk && !capEn && flags.thrOk;
    strobe.toLow  = voltTurn && flags.isHigh && flags.belowLow;
    strobe.toHigh = voltTurn && !flags.isHigh && flags.aboveHigh;
    strobe.freqDn = winValid && capEn && flags.overBudget;
    strobe.freqUp = winValid && capEn && !flags.overBudget;
  end

  // Blanking window counter, reloaded on every mode switch.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blankCnt <= '0;
    end else if (strobe.toLow || strobe.toHigh) begin
      blankCnt <= blankWin;
    end else if (winValid && blankCnt != '0) begin
      blankCnt <= blankCnt - 1'b1;
    end
  end

  // R6: no mode switch while windows are being blanked
  a_r6_blank_no_switch: assert property (@(posedge clk) disable iff (!rstN)
    (blankCnt != '0) |-> !(strobe.toLow || strobe.toHigh));
  // R6: the counter only moves on windows or switches
  a_r6_blank_on_window: assert property (@(posedge clk) disable iff (!rstN)
    !winValid |=> $stable(blankCnt));
  // R8: at most one strobe per cycle
  a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));
endmodule

// File: rtl/trs_top.sv
module trs_top
  import trs_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int COEF_W  = 8,
  parameter int FREQ_W  = 3,
  parameter int BLANK_W = 4,
  localparam int EST_W  = COEF_W + 2*CNT_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               winValid,
  input  logic [CNT_W-1:0]   winCount,
  input  logic               capEn,
  input  logic [CNT_W-1:0]   thrLow,
  input  logic [CNT_W-1:0]   thrHigh,
  input  logic [BLANK_W-1:0] blankWin,
  input  logic [COEF_W-1:0]  coefQuad,
  input  logic [COEF_W-1:0]  coefLin,
  input  logic [COEF_W-1:0]  coefConst,
  input  logic [EST_W-1:0]   budget,
  output logic               modeHigh,
  output logic [FREQ_W-1:0]  freqCode
);
  trs_flags_t  flags;
  trs_strobe_t strobe;

  trs_control #(.BLANK_W(BLANK_W)) ctl_i (
    .clk(clk), .rstN(rstN), .winValid(winValid), .capEn(capEn),
    .blankWin(blankWin), .flags(flags), .strobe(strobe)
  );

  trs_datapath #(.CNT_W(CNT_W), .COEF_W(COEF_W), .FREQ_W(FREQ_W), .EST_W(EST_W)) dp_i (
    .clk(clk), .rstN(rstN), .winCount(winCount), .thrLow(thrLow), .thrHigh(thrHigh),
    .coefQuad(coefQuad), .coefLin(coefLin), .coefConst(coefConst), .budget(budget),
    .strobe(strobe), .flags(flags), .modeHigh(modeHigh), .freqCode(freqCode)
  );

  // R7: nothing moves without a window
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !winValid |=> ($stable(modeHigh) && $stable(freqCode)));
  // R10: each operation leaves the other output alone
  a_r10_cap_holds_mode: assert property (@(posedge clk) disable iff (!rstN)
    capEn |=> $stable(modeHigh));
  a_r10_volt_holds_freq: assert property (@(posedge clk) disable iff (!rstN)
    !capEn |=> $stable(freqCode));
endmodule

// File: tb/trs_top_tb_top.sv
module trs_top_tb_top;
  localparam int CNT_W = 8, COEF_W = 8, FREQ_W = 3, BLANK_W = 4;
  localparam int EST_W = COEF_W + 2*CNT_W + 1;
  localparam int FMAX = (1 << FREQ_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic winValid = 1'b0;
  logic [CNT_W-1:0] winCount = '0;
  logic capEn = 1'b0;
  logic [CNT_W-1:0] thrLow = 8'd40, thrHigh = 8'd100;
  logic [BLANK_W-1:0] blankWin = '0;
  logic [COEF_W-1:0] coefQuad = 8'd1, coefLin = 8'd2, coefConst = 8'd5;
  logic [EST_W-1:0] budget = EST_W'(2000);
  logic modeHigh;
  logic [FREQ_W-1:0] freqCode;

  int nChecks = 0, nFails = 0;
  bit done = 0;
  // bench reference model
  int mHigh = 1, mFreq = FMAX, mBlank = 0;

  always #2.5 clk = ~clk;

  trs_top #(.CNT_W(CNT_W), .COEF_W(COEF_W), .FREQ_W(FREQ_W), .BLANK_W(BLANK_W)) dut_i (
    .clk(clk), .rstN(rstN), .winValid(winValid), .winCount(winCount), .capEn(capEn),
    .thrLow(thrLow), .thrHigh(thrHigh), .blankWin(blankWin), .coefQuad(coefQuad),
    .coefLin(coefLin), .coefConst(coefConst), .budget(budget),
    .modeHigh(modeHigh), .freqCode(freqCode)
  );

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint estOf(int n);
    return longint'(coefQuad) * n * n + longint'(coefLin) * n + longint'(coefConst);
  endfunction

  // Present one window, advance the model, compare both outputs.
  task automatic window(int n, string forced = "");
    string mTag, fTag;
    int wasHigh = mHigh, wasFreq = mFreq;
    mTag = capEn ? "R10" : "R4";
    fTag = capEn ? "R8" : "R10";
    if (mBlank > 0) begin
      mBlank--;
      if (!capEn) mTag = "R6";
    end else if (!capEn) begin
      if (thrLow > thrHigh) mTag = "R5";
      else if (mHigh == 1 && n < thrLow) begin mHigh = 0; mBlank = blankWin; mTag = "R2"; end
      else if (mHigh == 0 && n > thrHigh) begin mHigh = 1; mBlank = blankWin; mTag = "R3"; end
    end
    if (capEn) begin
      if (estOf(n) > longint'(budget)) mFreq = (mFreq > 0) ? mFreq - 1 : 0;
      else mFreq = (mFreq < FMAX) ? mFreq + 1 : FMAX;
      if (mFreq == wasFreq) fTag = "R9";
    end
    if (forced != "") begin mTag = forced; fTag = forced; end
    @(negedge clk);
    winValid = 1'b1;
    winCount = CNT_W'(n);
    @(negedge clk);
    winValid = 1'b0;
    check(mTag, int'(modeHigh), mHigh);
    check(fTag, int'(freqCode), mFreq);
    if (wasHigh != mHigh && wasHigh == 2) $display("unreachable");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", int'(modeHigh), 1);
    check("R1", int'(freqCode), FMAX);

    // R7: counts without winValid are ignored
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      winCount = 8'd0;
      capEn = i[0];
    end
    capEn = 1'b0;
    @(negedge clk);
    check("R7", int'(modeHigh), 1);
    check("R7", int'(freqCode), FMAX);

    // R2/R3/R4: ramp up and down through both thresholds, no blanking
    for (int n = 255; n >= 0; n--) window(n);
    for (int n = 0; n < 256; n++) window(n);
    for (int n = 255; n >= 0; n -= 3) window(n);
    // boundaries: exactly at the thresholds holds
    window(101); window(40); window(39); window(100); window(101);

    // R5: inverted thresholds hold the mode
    thrLow = 8'd120; thrHigh = 8'd50;
    window(0); window(255); window(10); window(200); window(0);

    // R6: blanking of three windows after each switch
    thrLow = 8'd40; thrHigh = 8'd100; blankWin = 4'd3;
    window(200); window(10);
    window(255); window(255); window(255); window(255);
    window(0); window(0); window(0); window(0);
    blankWin = 4'd0;

    // R8/R9/R10: power cap sweep, mode frozen
    capEn = 1'b1;
    for (int n = 0; n < 256; n++) window(n);
    for (int n = 0; n < 30; n++) window(0);
    for (int n = 255; n >= 0; n -= 5) window(n);

    // R11: budget rewrite applies at once, equality steps up
    budget = EST_W'(estOf(43));
    window(43, "R11"); window(43, "R11");
    budget = EST_W'(estOf(43) - 1);
    window(43, "R11"); window(43, "R11");
    coefQuad = 8'd3; coefLin = 8'd0; coefConst = 8'd200;
    budget = EST_W'(estOf(20));
    window(20, "R8"); window(21, "R8"); window(19, "R8");

    // R10: blanking still counts down during power cap
    capEn = 1'b0; blankWin = 4'd2;
    window(200); window(0); capEn = 1'b1; window(255); window(255);
    capEn = 1'b0; window(255);
    blankWin = 4'd0;

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule